// File: doc/BRIEF.md
# Serial Register Write Port

This block lets a host microcontroller program a small bank of 8-bit configuration registers over a three-wire serial link. The link has a select line, a bit clock and a data line. The block runs on a fast system clock. It brings the three serial lines into that clock domain with synchronizers and acts on each rising edge of the serial bit clock. The register contents are driven out in parallel, so the datapath sees them continuously. One configuration field is also decoded onto a dedicated output.

Each transaction opens with a device byte. That byte holds a fixed 7-bit identifier followed by a direction bit. A pointer byte comes next, then any number of data bytes. The pointer byte selects the first register. Its top bit chooses between two modes: writing every data byte to the same register, or stepping through successive registers with wrap-around. If the identifier does not match, or the direction bit asks for a read, the block ignores the rest of the transaction. Releasing the select line at any point throws away a partly received byte and returns the block to waiting for a device byte.

Top module: `spi_cfg_port`

## Requirements
- R1: After reset every register reads 0 and `speed_sel` is 0.
- R2: Bits are taken most significant first on rising edges of `cclk` while `cs_n` is low. The first byte must be the identifier 1001111 in bits 7:1, with bit 0 as the direction flag (0 = write).
- R3: When the identifier does not match, no register changes for the rest of that select period. The next select period is decoded normally.
- R4: A device byte with the direction flag at 1 leaves every register unchanged.
- R5: In the pointer byte, bits PTR_W-1:0 select the first register and bit 7 is the step flag.
- R6: With the step flag at 0, every data byte goes to the same register, so the last byte sent is the value that remains.
- R7: With the step flag at 1, each data byte goes to the next register. After register NUM_REGS-1 the pointer wraps to register 0.
- R8: Raising `cs_n` in the middle of a byte discards that byte and keeps all register values. The next transaction must start again with a device byte.
- R9: `speed_sel` always equals bits 5:4 of register 3.
- R10: A transaction that ends right after its pointer byte writes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 8 times the serial bit rate |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Serial select, active low |
| cclk | input | 1 | Serial bit clock |
| cdin | input | 1 | Serial data in |
| reg_bank | output | NUM_REGS*8 | All registers, register i at bits 8i+7:8i |
| speed_sel | output | 2 | Bits 5:4 of register 3 |

## Verification
The hardest condition to reach is a select release that lands in the middle of a byte, because only the bit-level timing of the stimulus can produce it. The bench drives the serial lines bit by bit, so it can stop a transaction after any number of clock pulses. It sweeps that cut point across positions inside both the pointer byte and a data byte. Wrap-around is reached by sweeping step-mode block writes over every start register, with bursts long enough to cross the top of the bank.

// File: rtl/spi_cfg_pkg.sv
package spi_cfg_pkg;
  typedef enum logic [1:0] {PH_DEV, PH_PTR, PH_DATA, PH_SKIP} phase_t;
  localparam logic [6:0] DEV_ID = 7'b1001111;
endpackage

// File: rtl/spi_cfg_sync.sv
module spi_cfg_sync #(
  parameter int W = 3,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] meta;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta <= RST_VAL;
      q    <= RST_VAL;
    end else begin
      meta <= d;
      q    <= meta;
    end
  end
endmodule

// File: rtl/spi_cfg_shift.sv
module spi_cfg_shift (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cs_n_s,
  input  logic       cclk_s,
  input  logic       din_s,
  output logic       byte_done,
  output logic [7:0] byte_val
);
  logic       cclk_q;
  logic [2:0] bit_cnt, bit_cnt_nx;
  logic [6:0] shreg, shreg_nx;
  logic       done_nx;
  logic [7:0] val_nx;
  logic       rise;

  assign rise = cclk_s & ~cclk_q & ~cs_n_s;

  always_comb begin
    bit_cnt_nx = bit_cnt;
    shreg_nx   = shreg;
    done_nx    = 1'b0;
    val_nx     = byte_val;
    if (cs_n_s) begin
      bit_cnt_nx = '0;
    end else if (rise) begin
      shreg_nx   = {shreg[5:0], din_s};
      bit_cnt_nx = bit_cnt + 3'd1;
      if (bit_cnt == 3'd7) begin
        done_nx = 1'b1;
        val_nx  = {shreg, din_s};
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cclk_q    <= 1'b0;
      bit_cnt   <= '0;
      shreg     <= '0;
      byte_done <= 1'b0;
      byte_val  <= '0;
    end else begin
      cclk_q    <= cclk_s;
      bit_cnt   <= bit_cnt_nx;
      shreg     <= shreg_nx;
      byte_done <= done_nx;
      byte_val  <= val_nx;
    end
  end
endmodule

// File: rtl/spi_cfg_seq.sv
module spi_cfg_seq
  import spi_cfg_pkg::*;
#(
  parameter int NUM_REGS = 8,
  localparam int PTR_W = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cs_idle,
  input  logic             byte_done,
  input  logic [7:0]       byte_val,
  output phase_t           phase,
  output logic [PTR_W-1:0] ptr,
  output logic             step,
  output logic             wr_en,
  output logic [PTR_W-1:0] wr_addr,
  output logic [7:0]       wr_data
);
  localparam logic [PTR_W-1:0] LAST = PTR_W'(NUM_REGS - 1);

  phase_t           phase_nx;
  logic [PTR_W-1:0] ptr_nx, wr_addr_nx;
  logic             step_nx, wr_en_nx;
  logic [7:0]       wr_data_nx;

  always_comb begin
    phase_nx   = phase;
    ptr_nx     = ptr;
    step_nx    = step;
    wr_en_nx   = 1'b0;
    wr_addr_nx = wr_addr;
    wr_data_nx = wr_data;
    if (cs_idle) begin
      phase_nx = PH_DEV;
    end else if (byte_done) begin
      case (phase)
        PH_DEV: begin
          if (byte_val[7:1] == DEV_ID && !byte_val[0]) phase_nx = PH_PTR;
          else                                           phase_nx = PH_SKIP;
        end
        PH_PTR: begin
          ptr_nx   = byte_val[PTR_W-1:0];
          step_nx  = byte_val[7];
          phase_nx = PH_DATA;
        end
        PH_DATA: begin
          wr_en_nx   = (32'(ptr) < NUM_REGS);
          wr_addr_nx = ptr;
          wr_data_nx = byte_val;
          if (step) ptr_nx = (ptr == LAST) ? '0 : ptr + 1'b1;
        end
        default: phase_nx = PH_SKIP;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase   <= PH_DEV;
      ptr     <= '0;
      step    <= 1'b0;
      wr_en   <= 1'b0;
      wr_addr <= '0;
      wr_data <= '0;
    end else begin
      phase   <= phase_nx;
      ptr     <= ptr_nx;
      step    <= step_nx;
      wr_en   <= wr_en_nx;
      wr_addr <= wr_addr_nx;
      wr_data <= wr_data_nx;
    end
  end
endmodule

// File: rtl/spi_cfg_regs.sv
module spi_cfg_regs #(
  parameter int NUM_REGS = 8,
  localparam int PTR_W = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  wr_en,
  input  logic [PTR_W-1:0]      wr_addr,
  input  logic [7:0]            wr_data,
  output logic [NUM_REGS*8-1:0] bank
);
  for (genvar i = 0; i < NUM_REGS; i++) begin : g_reg
    logic hit;
    assign hit = wr_en && (wr_addr == PTR_W'(i));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   bank[i*8 +: 8] <= '0;
      else if (hit) bank[i*8 +: 8] <= wr_data;
    end
  end
endmodule

// File: rtl/spi_cfg_port.sv
module spi_cfg_port
  import spi_cfg_pkg::*;
#(
  parameter int NUM_REGS = 8,
  localparam int PTR_W = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  cs_n,
  input  logic                  cclk,
  input  logic                  cdin,
  output logic [NUM_REGS*8-1:0] reg_bank,
  output logic [1:0]            speed_sel
);
  logic             cs_n_s, cclk_s, din_s;
  logic             byte_done;
  logic [7:0]       byte_val;
  phase_t           phase;
  logic [PTR_W-1:0] ptr, wr_addr;
  logic             step, wr_en;
  logic [7:0]       wr_data;

  spi_cfg_sync #(.W(3), .RST_VAL(3'b100)) u_sync (
    .clk(clk), .rst_n(rst_n),
    .d({cs_n, cclk, cdin}), .q({cs_n_s, cclk_s, din_s})
  );

  spi_cfg_shift u_shift (
    .clk(clk), .rst_n(rst_n), .cs_n_s(cs_n_s), .cclk_s(cclk_s),
    .din_s(din_s), .byte_done(byte_done), .byte_val(byte_val)
  );

  spi_cfg_seq #(.NUM_REGS(NUM_REGS)) u_seq (
    .clk(clk), .rst_n(rst_n), .cs_idle(cs_n_s), .byte_done(byte_done),
    .byte_val(byte_val), .phase(phase), .ptr(ptr), .step(step),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data)
  );

  spi_cfg_regs #(.NUM_REGS(NUM_REGS)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .bank(reg_bank)
  );

  if (NUM_REGS > 3) begin : g_speed
    assign speed_sel = reg_bank[3*8+4 +: 2];
  end else begin : g_nospeed
    assign speed_sel = 2'b00;
  end
endmodule

// File: rtl/spi_cfg_port_chk.sv
module spi_cfg_port_chk
  import spi_cfg_pkg::*;
#(
  parameter int NUM_REGS = 8,
  localparam int PTR_W = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  cs_n_s,
  input logic                  byte_done,
  input phase_t                phase,
  input logic [PTR_W-1:0]      ptr,
  input logic                  step,
  input logic                  wr_en,
  input logic [NUM_REGS*8-1:0] reg_bank
);
  p_bank_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(reg_bank));
  p_wr_after_byte_r2: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> $past(byte_done));
  p_single_write_r7: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> !wr_en);
  p_abort_to_dev_r8: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n_s |=> (phase == PH_DEV));
  p_skip_sticky_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_SKIP && !cs_n_s) |=> (phase == PH_SKIP));
  p_ptr_fixed_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_DATA && !step && !cs_n_s) |=> $stable(ptr));
endmodule

bind spi_cfg_port spi_cfg_port_chk #(.NUM_REGS(NUM_REGS)) u_chk (
  .clk(clk), .rst_n(rst_n), .cs_n_s(cs_n_s), .byte_done(byte_done),
  .phase(phase), .ptr(ptr), .step(step), .wr_en(wr_en), .reg_bank(reg_bank)
);

// File: tb/sim_spi_cfg_port.sv
module sim_spi_cfg_port;
  localparam int N = 8;
  localparam int HALF = 4;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cs_n = 1'b1, cclk = 1'b0, cdin = 1'b0;
  logic [N*8-1:0] reg_bank;
  logic [1:0] speed_sel;
  logic [7:0] exp_r [N];
  int checks = 0, fails = 0;

  always #5 clk = ~clk;

  spi_cfg_port #(.NUM_REGS(N)) u0 (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .cclk(cclk), .cdin(cdin),
    .reg_bank(reg_bank), .speed_sel(speed_sel)
  );

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic send_bits(input logic [7:0] b, input int nbits);
    for (int i = 7; i > 7 - nbits; i--) begin
      cdin = b[i];
      wait_clk(HALF);
      cclk = 1'b1;
      wait_clk(HALF);
      cclk = 1'b0;
    end
  endtask

  task automatic sel(); cs_n = 1'b0; wait_clk(HALF); endtask
  task automatic desel(); wait_clk(HALF); cs_n = 1'b1; wait_clk(8); endtask

  function automatic logic [7:0] dev_byte(input logic rd);
    return {7'b1001111, rd};
  endfunction

  task automatic check_all(input string req);
    for (int i = 0; i < N; i++) begin
      checks++;
      if (reg_bank[i*8 +: 8] !== exp_r[i]) begin
        fails++;
        $display("FAIL %s reg%0d actual=%02h expected=%02h", req, i, reg_bank[i*8 +: 8], exp_r[i]);
      end
    end
    checks++;
    if (speed_sel !== exp_r[3][5:4]) begin
      fails++;
      $display("FAIL R9 speed_sel actual=%0d expected=%0d (%s)", speed_sel, exp_r[3][5:4], req);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=running expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    for (int i = 0; i < N; i++) exp_r[i] = 8'h00;
    wait_clk(3);
    rst_n = 1'b1;
    wait_clk(4);
    check_all("R1 reset");

    // R6: fixed pointer, last byte remains, for every register
    for (int p = 0; p < N; p++) begin
      sel(); send_bits(dev_byte(1'b0), 8); send_bits(8'(p), 8);
      for (int k = 0; k < 3; k++) send_bits(8'(p * 17 + k * 5 + 1), 8);
      desel();
      exp_r[p] = 8'(p * 17 + 2 * 5 + 1);
      check_all("R6 fixed pointer");
    end

    // R7 / R5: step mode from every start, crossing the top (wrap)
    for (int p = 0; p < N; p++) begin
      sel(); send_bits(dev_byte(1'b0), 8); send_bits(8'h80 | 8'(p), 8);
      for (int k = 0; k < 5; k++) begin
        send_bits(8'(8'hA0 ^ (p * 8 + k)), 8);
        exp_r[(p + k) % N] = 8'(8'hA0 ^ (p * 8 + k));
      end
      desel();
      check_all("R7 step with wrap");
    end

    // R5: pointer bits above PTR_W are ignored, step bit drives mode
    sel(); send_bits(dev_byte(1'b0), 8); send_bits(8'h7B, 8); send_bits(8'h3C, 8); send_bits(8'h3D, 8);
    desel();
    exp_r[3] = 8'h3D;
    check_all("R5 pointer low bits");

    // R3: each single-bit mismatch of the identifier, then a good one
    for (int b = 1; b < 8; b++) begin
      logic [7:0] bad;
      bad = dev_byte(1'b0) ^ (8'h1 << b);
      sel(); send_bits(bad, 8); send_bits(8'h81, 8); send_bits(8'hEE, 8); send_bits(8'hEF, 8);
      desel();
      check_all("R3 bad identifier");
    end
    sel(); send_bits(dev_byte(1'b0), 8); send_bits(8'h01, 8); send_bits(8'h5A, 8); desel();
    exp_r[1] = 8'h5A;
    check_all("R3 next period decoded");

    // R4: read direction ignored
    sel(); send_bits(dev_byte(1'b1), 8); send_bits(8'h82, 8); send_bits(8'h11, 8); send_bits(8'h22, 8);
    desel();
    check_all("R4 read ignored");

    // R10: pointer only
    sel(); send_bits(dev_byte(1'b0), 8); send_bits(8'h04, 8); desel();
    check_all("R10 pointer only");

    // R8: cut inside pointer byte and inside a data byte at every bit
    for (int cut = 1; cut < 8; cut++) begin
      sel(); send_bits(dev_byte(1'b0), 8); send_bits(8'h85, cut); desel();
      check_all("R8 cut in pointer");
      sel(); send_bits(dev_byte(1'b0), 8); send_bits(8'h86, 8); send_bits(8'(cut * 3), 8);
      send_bits(8'hFF, cut); desel();
      exp_r[6] = 8'(cut * 3);
      check_all("R8 cut in data");
      // new period without device byte: pointer byte taken as device byte
      sel(); send_bits(8'h02, 8); send_bits(8'h99, 8); desel();
      check_all("R8 restart needs device byte");
    end

    // R9 / R2: speed field values via register 3, MSB-first patterns
    for (int s = 0; s < 4; s++) begin
      sel(); send_bits(dev_byte(1'b0), 8); send_bits(8'h03, 8); send_bits(8'(s << 4) | 8'h81, 8); desel();
      exp_r[3] = 8'(s << 4) | 8'h81;
      check_all("R9 R2 speed field");
    end

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule